// File: doc/BRIEF.md
# Page Access Permission Checker with Reference/Change Update

This block judges one memory access against a leaf translation entry. A request carries the 64-bit entry, the access kind (read, write or execute), the processor's user/supervisor state, the read/write/execute permissions already decoded from the entry's access-authority field, and the permissions from the authority-mask register. The block decides whether the access may proceed and reports the fault causes. It returns the permission set the access may be cached with.

When the access is allowed, the block also marks the entry as referenced and, for writes, as changed. If the marked entry differs from the original, it is offered on a write-back port before the answer is returned. A read or execute is granted a permission set with write removed. A later store then has to come back through the block, which sets the change bit at that point.

The request side accepts one request at a time while `req_ready_o` is high. The answer appears as a one-cycle pulse on `rsp_valid_o`.

Top module: `pte_access_check`

## Requirements
- R1: If the entry's 2-bit attribute field (bits 5:4) holds the non-idempotent I/O code 2'b10 and the access is an execute, the access is denied with fault bit 0 (guarded no-execute) set and fault bit 1 clear.
- R2: For an entry with the privileged bit (bit 3) set, accessed in user state (`user_mode_i`=1), the granted set is empty.
- R3: In user state with a non-privileged entry, or in supervisor state with a privileged entry, the granted set equals `auth_perm_i`. Permission bits are bit 0 read, bit 1 write, bit 2 execute.
- R4: In supervisor state with a non-privileged entry, the granted set is `auth_perm_i & mask_perm_i`.
- R5: When R1 does not apply and the permission bit that the access kind needs (encoding 0 read, 1 write, 2 execute) is missing from the granted set, the access is denied with fault bit 1 (protection) set.
- R6: Access encoding 3 is illegal and is always denied as a protection fault.
- R7: An allowed access produces an updated entry with the reference bit (bit 8) set, and with the change bit (bit 7) set only for a write. All other bits are unchanged.
- R8: For an allowed access, `rsp_perm_o` is the granted set, except that for a read or an execute the write bit is cleared. For a denied access, `rsp_perm_o` is zero.
- R9: The updated entry is offered on the write-back port exactly once per request, and only when it differs from the original entry. Nothing is written back for a denied access.
- R10: A denied write additionally sets fault bit 2 (store indication). No other denied access sets it.
- R11: After reset, `req_ready_o` is high and `rsp_valid_o` and `wb_valid_o` are low.
- R12: Each accepted request gets exactly one `rsp_valid_o` pulse, one cycle long. It comes after any write-back handshake has completed. `req_ready_o` is low from acceptance until the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| pte_i | input | 64 | Leaf translation entry |
| access_i | input | 2 | 0 read, 1 write, 2 execute, 3 illegal |
| user_mode_i | input | 1 | Processor in user (problem) state |
| auth_perm_i | input | 3 | Permissions decoded from the entry's authority field |
| mask_perm_i | input | 3 | Permissions from the authority-mask register |
| rsp_valid_o | output | 1 | One-cycle answer strobe |
| rsp_allow_o | output | 1 | Access allowed |
| rsp_fault_o | output | 3 | Fault bits: 0 guarded, 1 protection, 2 store |
| rsp_perm_o | output | 3 | Permission set granted for caching |
| wb_valid_o | output | 1 | Updated entry offered for write-back |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_data_o | output | 64 | Updated entry |

## Verification
The assertions assume that `wb_ready_i` is only meaningful while `wb_valid_o` is high. They also assume that request fields matter only in a cycle in which `req_valid_i` and `req_ready_o` are both high. The bench stays within this. It raises a request for a single accepted cycle and then drops it. It drives `wb_ready_i` only in response to an observed `wb_valid_o`, and withholds it for one cycle on every other write-back to exercise the hold.

// File: rtl/pte_access_pkg.sv
package pte_access_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int P_RD     = 0;
  localparam int P_WR     = 1;
  localparam int P_EX     = 2;

  localparam int FAULT_W  = 3;
  localparam int F_GUARD  = 0;
  localparam int F_PROT   = 1;
  localparam int F_STORE  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_RSP  = 2'd2
  } st_e;
endpackage

// File: rtl/perm_eval.sv
module perm_eval
  import pte_access_pkg::*;
(
  input  acc_e              acc_i,
  input  logic              user_i,
  input  logic              priv_i,
  input  logic              nio_i,
  input  logic [PERM_W-1:0] auth_i,
  input  logic [PERM_W-1:0] mask_i,
  output logic              allow_o,
  output logic [FAULT_W-1:0] fault_o,
  output logic [PERM_W-1:0] perm_o
);
  logic [PERM_W-1:0] granted;
  logic              need_ok, guard, prot, denied;

  always_comb begin
    if (priv_i && user_i)      granted = '0;
    else if (user_i || priv_i) granted = auth_i;
    else                       granted = auth_i & mask_i;
  end

  always_comb begin
    unique case (acc_i)
      ACC_RD:  need_ok = granted[P_RD];
      ACC_WR:  need_ok = granted[P_WR];
      ACC_EX:  need_ok = granted[P_EX];
      default: need_ok = 1'b0;
    endcase
  end

  assign guard  = nio_i && (acc_i == ACC_EX);
  assign prot   = !guard && !need_ok;
  assign denied = guard || prot;
  assign allow_o = !denied;

  always_comb begin
    fault_o          = '0;
    fault_o[F_GUARD] = guard;
    fault_o[F_PROT]  = prot;
    fault_o[F_STORE] = denied && (acc_i == ACC_WR);
  end

  // reads/executes are cached without write so a later store revisits RC
  always_comb begin
    perm_o = '0;
    if (!denied) begin
      perm_o = granted;
      if (acc_i != ACC_WR) perm_o[P_WR] = 1'b0;
    end
  end
endmodule

// File: rtl/rc_update.sv
module rc_update #(
  parameter int PTE_W   = 64,
  parameter int REF_BIT = 8,
  parameter int CHG_BIT = 7
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  output logic [PTE_W-1:0] pte_o,
  output logic             changed_o
);
  always_comb begin
    pte_o          = pte_i;
    pte_o[REF_BIT] = 1'b1;
    if (is_write_i) pte_o[CHG_BIT] = 1'b1;
  end

  assign changed_o = (pte_o != pte_i);
endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
  import pte_access_pkg::*;
#(
  parameter int         PTE_W    = 64,
  parameter int         ATT_LSB  = 4,
  parameter logic [1:0] NIO_CODE = 2'b10,
  parameter int         PRIV_BIT = 3,
  parameter int         REF_BIT  = 8,
  parameter int         CHG_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PTE_W-1:0]  pte_i,
  input  logic [1:0]        access_i,
  input  logic              user_mode_i,
  input  logic [2:0]        auth_perm_i,
  input  logic [2:0]        mask_perm_i,
  output logic              rsp_valid_o,
  output logic              rsp_allow_o,
  output logic [2:0]        rsp_fault_o,
  output logic [2:0]        rsp_perm_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [PTE_W-1:0]  wb_data_o
);
  localparam int ATT_MSB = ATT_LSB + 1;

  acc_e               acc;
  logic               allow_d, changed_d, take;
  logic [FAULT_W-1:0] fault_d;
  logic [PERM_W-1:0]  perm_d;
  logic [PTE_W-1:0]   pte_d;

  st_e                state_q;
  logic               allow_q;
  logic [FAULT_W-1:0] fault_q;
  logic [PERM_W-1:0]  perm_q;
  logic [PTE_W-1:0]   pte_q;

  assign acc  = acc_e'(access_i);
  assign take = req_valid_i && req_ready_o;

  perm_eval u_perm (
    .acc_i   (acc),
    .user_i  (user_mode_i),
    .priv_i  (pte_i[PRIV_BIT]),
    .nio_i   (pte_i[ATT_MSB:ATT_LSB] == NIO_CODE),
    .auth_i  (auth_perm_i),
    .mask_i  (mask_perm_i),
    .allow_o (allow_d),
    .fault_o (fault_d),
    .perm_o  (perm_d)
  );

  rc_update #(.PTE_W(PTE_W), .REF_BIT(REF_BIT), .CHG_BIT(CHG_BIT)) u_rc (
    .pte_i      (pte_i),
    .is_write_i (acc == ACC_WR),
    .pte_o      (pte_d),
    .changed_o  (changed_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      allow_q <= 1'b0;
      fault_q <= '0;
      perm_q  <= '0;
      pte_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          allow_q <= allow_d;
          fault_q <= fault_d;
          perm_q  <= perm_d;
          pte_q   <= pte_d;
          state_q <= (allow_d && changed_d) ? ST_WB : ST_RSP;
        end
        ST_WB:   if (wb_ready_i) state_q <= ST_RSP;
        ST_RSP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign wb_valid_o  = (state_q == ST_WB);
  assign wb_data_o   = pte_q;
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_allow_o = allow_q;
  assign rsp_fault_o = fault_q;
  assign rsp_perm_o  = perm_q;
endmodule

// File: rtl/pte_access_check_sva.sv
module pte_access_check_sva #(
  parameter int PTE_W   = 64,
  parameter int REF_BIT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_allow_o,
  input logic [2:0]       rsp_fault_o,
  input logic [2:0]       rsp_perm_o,
  input logic             wb_valid_o,
  input logic             wb_ready_i,
  input logic [PTE_W-1:0] wb_data_o
);
  assert_rsp_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  assert_busy_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !wb_valid_o);

  assert_wb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_data_o));

  assert_wb_then_rsp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_ready_i |=> rsp_valid_o && rsp_allow_o);

  assert_wb_ref_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_data_o[REF_BIT]);

  assert_deny_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_allow_o |-> rsp_perm_o == 3'b000 && rsp_fault_o[1:0] != 2'b00);

  assert_allow_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_allow_o |-> rsp_fault_o == 3'b000);

  assert_one_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones(rsp_fault_o[1:0]) <= 1);
endmodule

bind pte_access_check pte_access_check_sva #(.PTE_W(PTE_W), .REF_BIT(REF_BIT)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_allow_o (rsp_allow_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_perm_o  (rsp_perm_o),
  .wb_valid_o  (wb_valid_o),
  .wb_ready_i  (wb_ready_i),
  .wb_data_o   (wb_data_o)
);

// File: tb/tb_pte_access_check.sv
`timescale 1ns/1ps
module tb_pte_access_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] pte = '0;
  logic [1:0]  access = '0;
  logic        user_mode = 1'b0;
  logic [2:0]  auth = '0;
  logic [2:0]  mask = '0;
  logic        rsp_valid, rsp_allow;
  logic [2:0]  rsp_fault, rsp_perm;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [63:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pte_access_check dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .pte_i(pte), .access_i(access), .user_mode_i(user_mode),
    .auth_perm_i(auth), .mask_perm_i(mask),
    .rsp_valid_o(rsp_valid), .rsp_allow_o(rsp_allow),
    .rsp_fault_o(rsp_fault), .rsp_perm_o(rsp_perm),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_data_o(wb_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int idx = 0;
    int wb_hs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !wb_valid, "R11",
          {rsp_valid, wb_valid, req_ready}, 3'b001);

    for (int a = 0; a < 4; a++)
    for (int u = 0; u < 2; u++)
    for (int pv = 0; pv < 2; pv++)
    for (int at = 0; at < 4; at++)
    for (int e = 0; e < 8; e++)
    for (int m = 0; m < 8; m++)
    for (int rc = 0; rc < 4; rc++) begin
      logic [2:0]  g, perm_e, fault_e;
      logic [63:0] pte_e;
      bit guard, prot, allow_e, wb_e, got_rsp, stall;
      string ptag, ftag;
      // expected
      guard = (at == 2) && (a == 2);
      if (pv && u)      begin g = 3'b000;           ptag = "R2"; end
      else if (u || pv) begin g = e[2:0];           ptag = "R3"; end
      else              begin g = e[2:0] & m[2:0];  ptag = "R4"; end
      prot    = !guard && ((a == 3) || !g[a[1:0]]);
      allow_e = !(guard || prot);
      fault_e = {(!allow_e && a == 1), prot, guard};
      perm_e  = !allow_e ? 3'b000 : (a == 1 ? g : (g & 3'b101));
      if (allow_e && a != 1) ptag = "R8";
      ftag = guard ? "R1" : (a == 3 ? "R6" : "R5");

      pte = 64'hC0DE_7000_0000_0000 ^ (64'(idx) << 12);
      pte[5:4] = at[1:0];
      pte[3]   = pv[0];
      pte[8]   = rc[1];
      pte[7]   = rc[0];
      pte_e = pte;
      pte_e[8] = 1'b1;
      if (a == 1) pte_e[7] = 1'b1;
      wb_e = allow_e && (pte_e != pte);
      stall = idx[0];

      access = a[1:0]; user_mode = u[0]; auth = e[2:0]; mask = m[2:0];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R12", req_ready, 0);

      wb_hs = 0;
      got_rsp = 0;
      for (int c = 0; c < 8 && !got_rsp; c++) begin
        wb_ready = 1'b0;
        if (rsp_valid) begin
          got_rsp = 1;
          check(rsp_allow == allow_e, ftag, rsp_allow, allow_e);
          check(rsp_fault[1:0] == fault_e[1:0], ftag, rsp_fault, fault_e);
          check(rsp_fault[2] == fault_e[2], "R10", rsp_fault, fault_e);
          check(rsp_perm == perm_e, ptag, rsp_perm, perm_e);
          check(wb_hs == (wb_e ? 1 : 0), "R9", wb_hs, wb_e);
        end else if (wb_valid) begin
          check(wb_data == pte_e, "R7", wb_data, pte_e);
          if (stall) stall = 0;
          else begin
            wb_ready = 1'b1;
            wb_hs++;
          end
        end
        @(negedge clk);
      end
      wb_ready = 1'b0;
      check(got_rsp, "R12", got_rsp, 1);
      check(!rsp_valid && req_ready, "R12", {rsp_valid, req_ready}, 2'b01);
      idx++;
    end
    finish_run();
  end
endmodule